// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This block moves a processor clock domain from one operating point to another. A request carries a target core frequency in MHz. The block looks that frequency up in a built-in table of operating points. It then drives an ordered series of single-step commands over one shared command bus. The commands go to the supply regulators, the cache-timing register, the core clock bypass mux, the core integer and fractional dividers, the bus divider and the memory-clock setter. After each command it waits for an acknowledge. Those targets sit outside the block, and each one acknowledges when its step has taken effect.

The order of the commands depends on the direction of the change. When the frequency goes up, the supply is raised before any clock changes. When it goes down, the clocks are slowed first and the supply is lowered last. In both directions the core runs from the crystal while its dividers are rewritten. Automatic bus slow-down is switched off for the whole transition.

A request for the frequency already in use does nothing. A request that matches no table entry raises a miss pulse. If a target fails to acknowledge within a set number of cycles, the block stops in a fault state until reset.

Top module: `opp_transition_seq`

## Requirements
- R1: After reset, `busy`, `done`, `miss`, `fault` and `cmd_valid` are low and `cur_freq` reads 24 (the crystal rate, which is not a table key).
- R2: A request whose `req_freq` equals `cur_freq` issues no command and raises neither `done` nor `miss`. `cur_freq` keeps its value.
- R3: A request that differs from `cur_freq` and matches no table key (454, 261, 64; the key 0 never matches) raises `miss` for one cycle in the cycle after it is accepted. No command is issued and `cur_freq` is unchanged.
- R4: Each step raises `cmd_valid` for exactly one cycle, with `cmd_kind`, `cmd_data` and `cmd_aux` valid in that cycle. The next strobe comes only after `cmd_ack` is seen high in a later cycle, and it appears in the cycle after that acknowledge. The kind codes are:
  - 0: slow-down off
  - 1: I/O supply
  - 2: core supply
  - 3: cache timing
  - 4: bypass on
  - 5: fractional divider
  - 6: integer divider
  - 7: bus divider
  - 8: bypass off
  - 9: memory clock
  - 10: slow-down on
- R5: Every transition starts with kind 0, then kind 1 with data 3300 and aux 3125. It ends with kind 10. The data and aux fields are 0 for kinds 0, 4, 8 and 10.
- R6: When the target is above `cur_freq`, the steps between the second and the last are 2, 3, 4, 5, 6, 7, 8, 9.
- R7: When the target is below `cur_freq`, the steps between the second and the last are 4, 7, 5, 6, 8, 9, 3, 2.
- R8: The payloads come from the target's table entry. For the core supply, data is the supply in mV and aux is the brown-out level in mV. Each divider step carries its divider value in data. The memory-clock step carries MHz in data, and the cache-timing step carries its code in data. The table entries are:

  | Freq (MHz) | Core supply (mV) | Brown-out (mV) | Bus div | Int div | Frac div | Memory clock (MHz) | Cache code |
  |---|---|---|---|---|---|---|---|
  | 454 | 1550 | 1450 | 3 | 1 | 19 | 130 | 0 |
  | 261 | 1275 | 1175 | 2 | 1 | 33 | 130 | 0 |
  | 64 | 1050 | 975 | 1 | 5 | 27 | 64 | 0 |
- R9: `busy` is high from the cycle after a request is accepted until the last acknowledge. In the cycle after that acknowledge, `done` is high for one cycle, `busy` is low and `cur_freq` holds the new frequency. `cur_freq` changes at no other time.
- R10: `req_valid` is ignored while `busy` is high. The transition under way completes with its original target, and no further command follows it.
- R11: If `cmd_ack` stays low for `ACK_TIMEOUT` cycles after a strobe, `fault` rises and stays high until reset. `busy` falls, no further command is issued, later requests are ignored and `cur_freq` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_freq | input | 16 | Requested core frequency, MHz |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| miss | output | 1 | One-cycle pulse: no table entry for the request |
| fault | output | 1 | Sticky acknowledge-timeout flag |
| cur_freq | output | 16 | Frequency currently in force, MHz |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 4 | Command kind code |
| cmd_data | output | 16 | Primary command payload |
| cmd_aux | output | 16 | Secondary payload (brown-out level) |
| cmd_ack | input | 1 | Acknowledge from the addressed target |

## Verification
The assertions check on every cycle that each strobe lasts one cycle and that a transition always opens with the slow-down-off step. They also check that `done` closes a busy period, that `cur_freq` moves only together with `done`, and that `fault` never clears. The order of the steps in each direction, the payload taken from each table row, and the handling of equal, unknown and mid-transition requests depend on the history of requests. Only the bench's request scenarios can show them, with varied acknowledge delays. The same holds for the timeout path and the clearing of the fault by reset.

// File: rtl/opp_seq_pkg.sv
`timescale 1ns/1ps
package opp_seq_pkg;

   localparam int FW          = 16;
   localparam int TABLE_DEPTH = 4;
   localparam int NUM_STEPS   = 11;
   localparam int IDX_W       = $clog2(NUM_STEPS);
   localparam logic [FW-1:0] IO_MV    = 16'd3300;
   localparam logic [FW-1:0] IO_BO_MV = 16'd3125;

   typedef enum logic [3:0] {
      K_SLOW_OFF    = 4'd0,
      K_IO_SUPPLY   = 4'd1,
      K_CORE_SUPPLY = 4'd2,
      K_CACHE_TIM   = 4'd3,
      K_BYPASS_ON   = 4'd4,
      K_FRAC_DIV    = 4'd5,
      K_INT_DIV     = 4'd6,
      K_BUS_DIV     = 4'd7,
      K_BYPASS_OFF  = 4'd8,
      K_MEM_CLK     = 4'd9,
      K_SLOW_ON     = 4'd10
   } step_kind_e;

   typedef enum logic [1:0] {
      S_IDLE, S_ISSUE, S_WAIT, S_FAULT
   } seq_state_e;

   typedef struct packed {
      logic [FW-1:0] freq;
      logic [FW-1:0] core_mv;
      logic [FW-1:0] core_bo_mv;
      logic [3:0]    bus_div;
      logic [3:0]    int_div;
      logic [5:0]    frac_div;
      logic [FW-1:0] mem_mhz;
      logic [3:0]    cache_code;
   } opp_entry_t;

   // Row 3 is the terminator: key 0 never matches.
   function automatic opp_entry_t opp_entry(input int idx);
      opp_entry_t e;
      e = '0;
      case (idx)
         0: e = '{freq: 16'd454, core_mv: 16'd1550, core_bo_mv: 16'd1450,
                  bus_div: 4'd3, int_div: 4'd1, frac_div: 6'd19,
                  mem_mhz: 16'd130, cache_code: 4'd0};
         1: e = '{freq: 16'd261, core_mv: 16'd1275, core_bo_mv: 16'd1175,
                  bus_div: 4'd2, int_div: 4'd1, frac_div: 6'd33,
                  mem_mhz: 16'd130, cache_code: 4'd0};
         2: e = '{freq: 16'd64, core_mv: 16'd1050, core_bo_mv: 16'd975,
                  bus_div: 4'd1, int_div: 4'd5, frac_div: 6'd27,
                  mem_mhz: 16'd64, cache_code: 4'd0};
         default: e = '0;
      endcase
      return e;
   endfunction

   function automatic bit key_in_table(input logic [FW-1:0] key);
      bit found;
      found = 1'b0;
      for (int i = 0; i < TABLE_DEPTH; i++)
         if (opp_entry(i).freq != '0 && opp_entry(i).freq == key) found = 1'b1;
      return found;
   endfunction

endpackage

// File: rtl/opp_profile_lookup.sv
`timescale 1ns/1ps
module opp_profile_lookup
   import opp_seq_pkg::*;
#(
   parameter int DEPTH = TABLE_DEPTH
)(
   input  logic [FW-1:0] key,
   output logic          hit,
   output opp_entry_t    entry
);

   if (DEPTH < 1 || DEPTH > TABLE_DEPTH) begin : g_bad_depth
      $error("opp_profile_lookup: DEPTH out of range");
   end

   opp_entry_t           rows  [DEPTH];
   logic [DEPTH-1:0]     match;

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      assign rows[i]  = opp_entry(i);
      assign match[i] = (rows[i].freq != '0) && (rows[i].freq == key);
   end

   always_comb begin
      hit   = |match;
      entry = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (match[i]) entry = rows[i];
   end

endmodule

// File: rtl/opp_step_order.sv
`timescale 1ns/1ps
module opp_step_order
   import opp_seq_pkg::*;
(
   input  logic             raising,
   input  logic [IDX_W-1:0] idx,
   output step_kind_e       kind
);

   // Supply first on the way up, supply last on the way down.
   always_comb begin
      kind = K_SLOW_ON;
      if (raising) begin
         case (idx)
            4'd0:  kind = K_SLOW_OFF;
            4'd1:  kind = K_IO_SUPPLY;
            4'd2:  kind = K_CORE_SUPPLY;
            4'd3:  kind = K_CACHE_TIM;
            4'd4:  kind = K_BYPASS_ON;
            4'd5:  kind = K_FRAC_DIV;
            4'd6:  kind = K_INT_DIV;
            4'd7:  kind = K_BUS_DIV;
            4'd8:  kind = K_BYPASS_OFF;
            4'd9:  kind = K_MEM_CLK;
            default: kind = K_SLOW_ON;
         endcase
      end else begin
         case (idx)
            4'd0:  kind = K_SLOW_OFF;
            4'd1:  kind = K_IO_SUPPLY;
            4'd2:  kind = K_BYPASS_ON;
            4'd3:  kind = K_BUS_DIV;
            4'd4:  kind = K_FRAC_DIV;
            4'd5:  kind = K_INT_DIV;
            4'd6:  kind = K_BYPASS_OFF;
            4'd7:  kind = K_MEM_CLK;
            4'd8:  kind = K_CACHE_TIM;
            4'd9:  kind = K_CORE_SUPPLY;
            default: kind = K_SLOW_ON;
         endcase
      end
   end

endmodule

// File: rtl/opp_payload.sv
`timescale 1ns/1ps
module opp_payload
   import opp_seq_pkg::*;
(
   input  step_kind_e    kind,
   input  opp_entry_t    prof,
   output logic [FW-1:0] data,
   output logic [FW-1:0] aux
);

   always_comb begin
      data = '0;
      aux  = '0;
      case (kind)
         K_IO_SUPPLY:   begin data = IO_MV;         aux = IO_BO_MV;        end
         K_CORE_SUPPLY: begin data = prof.core_mv;  aux = prof.core_bo_mv; end
         K_CACHE_TIM:   data = {{(FW-4){1'b0}}, prof.cache_code};
         K_FRAC_DIV:    data = {{(FW-6){1'b0}}, prof.frac_div};
         K_INT_DIV:     data = {{(FW-4){1'b0}}, prof.int_div};
         K_BUS_DIV:     data = {{(FW-4){1'b0}}, prof.bus_div};
         K_MEM_CLK:     data = prof.mem_mhz;
         default: ;
      endcase
   end

endmodule

// File: rtl/opp_transition_seq.sv
`timescale 1ns/1ps
module opp_transition_seq
   import opp_seq_pkg::*;
#(
   parameter int            ACK_TIMEOUT = 64,
   parameter logic [FW-1:0] RESET_FREQ  = 16'd24
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [15:0]   req_freq,
   output logic          busy,
   output logic          done,
   output logic          miss,
   output logic          fault,
   output logic [15:0]   cur_freq,
   output logic          cmd_valid,
   output logic [3:0]    cmd_kind,
   output logic [15:0]   cmd_data,
   output logic [15:0]   cmd_aux,
   input  logic          cmd_ack
);

   if (ACK_TIMEOUT < 0) begin : g_bad_timeout
      $error("opp_transition_seq: ACK_TIMEOUT must be >= 0");
   end
   if (RESET_FREQ == '0 || key_in_table(RESET_FREQ)) begin : g_bad_reset
      $error("opp_transition_seq: RESET_FREQ must be nonzero and not a table key");
   end

   seq_state_e        state;
   logic [IDX_W-1:0]  step_idx;
   logic              raising;
   opp_entry_t        tgt;
   logic [FW-1:0]     cur_q;
   logic              done_q, miss_q, fault_q;

   logic              hit;
   opp_entry_t        found;
   step_kind_e        kind_now;
   logic              expired;
   logic              accept;

   opp_profile_lookup #(.DEPTH(TABLE_DEPTH)) u_lookup (
      .key(req_freq), .hit(hit), .entry(found)
   );

   opp_step_order u_order (
      .raising(raising), .idx(step_idx), .kind(kind_now)
   );

   opp_payload u_payload (
      .kind(kind_now), .prof(tgt), .data(cmd_data), .aux(cmd_aux)
   );

   if (ACK_TIMEOUT > 0) begin : g_timer
      localparam int CW = $clog2(ACK_TIMEOUT + 1);
      logic [CW-1:0] wait_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               wait_cnt <= '0;
         else if (state == S_WAIT) wait_cnt <= wait_cnt + 1'b1;
         else                      wait_cnt <= '0;
      end
      assign expired = (state == S_WAIT) && (wait_cnt == CW'(ACK_TIMEOUT - 1));
   end else begin : g_no_timer
      assign expired = 1'b0;
   end

   assign accept = req_valid && (state == S_IDLE) && (req_freq != cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         step_idx <= '0;
         raising  <= 1'b0;
         tgt      <= '0;
         cur_q    <= RESET_FREQ;
         done_q   <= 1'b0;
         miss_q   <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         miss_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (accept) begin
                  if (hit) begin
                     tgt      <= found;
                     raising  <= (req_freq > cur_q);
                     step_idx <= '0;
                     state    <= S_ISSUE;
                  end else begin
                     miss_q <= 1'b1;
                  end
               end
            end
            S_ISSUE: state <= S_WAIT;
            S_WAIT: begin
               if (cmd_ack) begin
                  if (step_idx == IDX_W'(NUM_STEPS - 1)) begin
                     cur_q  <= tgt.freq;
                     done_q <= 1'b1;
                     state  <= S_IDLE;
                  end else begin
                     step_idx <= step_idx + 1'b1;
                     state    <= S_ISSUE;
                  end
               end else if (expired) begin
                  fault_q <= 1'b1;
                  state   <= S_FAULT;
               end
            end
            default: state <= S_FAULT;
         endcase
      end
   end

   assign busy      = (state == S_ISSUE) || (state == S_WAIT);
   assign cmd_valid = (state == S_ISSUE);
   assign cmd_kind  = kind_now;
   assign done      = done_q;
   assign miss      = miss_q;
   assign fault     = fault_q;
   assign cur_freq  = cur_q;

   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   p_first_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cmd_valid && cmd_kind == 4'd0));

   p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> (!busy && !cmd_valid));

   p_done_closes_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_cur_moves_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_freq != $past(cur_freq)) |-> done);

   p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (fault && !busy && !cmd_valid));

endmodule

// File: tb/opp_transition_seq_bench.sv
`timescale 1ns/1ps
module opp_transition_seq_bench;

   localparam int TMO = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_freq = '0;
   logic        cmd_ack = 1'b0;
   logic        busy, done, miss, fault, cmd_valid;
   logic [15:0] cur_freq, cmd_data, cmd_aux;
   logic [3:0]  cmd_kind;

   int n_chk = 0;
   int n_fail = 0;
   int model_cur = 24;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   opp_transition_seq #(.ACK_TIMEOUT(TMO)) u_opp_transition_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freq(req_freq),
      .busy(busy), .done(done), .miss(miss), .fault(fault), .cur_freq(cur_freq),
      .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
      .cmd_aux(cmd_aux), .cmd_ack(cmd_ack)
   );

   // Vector table: frequency, mode (0 same, 1 up, 2 down, 3 miss), ack delay, poke while busy
   localparam int NV = 9;
   localparam int V_FREQ [NV] = '{24, 64, 64, 454, 261, 100, 0, 64, 261};
   localparam int V_MODE [NV] = '{0,  1,  0,  1,   2,   3,   3, 2,  1};
   localparam int V_ACKD [NV] = '{1,  1,  1,  3,   2,   1,   1, 4,  1};
   localparam int V_POKE [NV] = '{0,  0,  0,  1,   0,   0,   0, 1,  0};

   localparam int UP_ORD [11] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10};
   localparam int DN_ORD [11] = '{0, 1, 4, 7, 5, 6, 8, 9, 3, 2, 10};

   task automatic check(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int row_of(input int f);
      if (f == 454) return 0;
      if (f == 261) return 1;
      return 2;
   endfunction

   function automatic int exp_data(input int kind, input int f);
      int r;
      int core [3] = '{1550, 1275, 1050};
      int bdiv [3] = '{3, 2, 1};
      int idiv [3] = '{1, 1, 5};
      int fdiv [3] = '{19, 33, 27};
      int mem  [3] = '{130, 130, 64};
      r = row_of(f);
      case (kind)
         1: return 3300;
         2: return core[r];
         5: return fdiv[r];
         6: return idiv[r];
         7: return bdiv[r];
         9: return mem[r];
         default: return 0;
      endcase
   endfunction

   function automatic int exp_aux(input int kind, input int f);
      int bo [3] = '{1450, 1175, 975};
      if (kind == 1) return 3125;
      if (kind == 2) return bo[row_of(f)];
      return 0;
   endfunction

   task automatic check_reset_state(input string tag);
      check({tag, " R1 busy"}, int'(busy), 0);
      check({tag, " R1 done"}, int'(done), 0);
      check({tag, " R1 miss"}, int'(miss), 0);
      check({tag, " R1 fault"}, int'(fault), 0);
      check({tag, " R1 cmd_valid"}, int'(cmd_valid), 0);
      check({tag, " R1 cur_freq"}, int'(cur_freq), 24);
   endtask

   task automatic run_vector(input int f, input int mode, input int ackd, input int poke);
      @(negedge clk);
      req_valid = 1'b1;
      req_freq  = 16'(f);
      @(negedge clk);
      req_valid = 1'b0;
      if (mode == 0) begin
         for (int k = 0; k < 4; k++) begin
            check("R2 no command", int'(cmd_valid), 0);
            check("R2 no done/miss", int'(done | miss | busy), 0);
            @(negedge clk);
         end
         check("R2 cur_freq", int'(cur_freq), model_cur);
      end else if (mode == 3) begin
         check("R3 miss pulse", int'(miss), 1);
         check("R3 no command", int'(cmd_valid | busy), 0);
         @(negedge clk);
         check("R3 miss one cycle", int'(miss), 0);
         check("R3 cur_freq", int'(cur_freq), model_cur);
      end else begin
         for (int s = 0; s < 11; s++) begin
            int ek;
            string rq;
            ek = (mode == 1) ? UP_ORD[s] : DN_ORD[s];
            rq = (s < 2 || s == 10) ? "R5" : ((mode == 1) ? "R6" : "R7");
            check("R4 strobe", int'(cmd_valid), 1);
            check("R9 busy", int'(busy), 1);
            check({rq, " kind"}, int'(cmd_kind), ek);
            check("R8 data", int'(cmd_data), exp_data(ek, f));
            check("R8 aux", int'(cmd_aux), exp_aux(ek, f));
            for (int w = 0; w < ackd; w++) begin
               @(negedge clk);
               if (poke != 0 && s == 4 && w == 0) begin
                  req_valid = 1'b1;
                  req_freq  = 16'd261;
               end else begin
                  req_valid = 1'b0;
               end
               check("R4 wait for ack", int'(cmd_valid), 0);
            end
            req_valid = 1'b0;
            cmd_ack = 1'b1;
            @(negedge clk);
            cmd_ack = 1'b0;
         end
         model_cur = f;
         check("R9 done pulse", int'(done), 1);
         check("R9 busy low", int'(busy), 0);
         check("R9 cur_freq", int'(cur_freq), f);
         @(negedge clk);
         check("R9 done one cycle", int'(done), 0);
         for (int k = 0; k < 3; k++) begin
            check("R10 no extra command", int'(cmd_valid | busy), 0);
            @(negedge clk);
         end
         check("R10 target kept", int'(cur_freq), f);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog R9: got 0 expected 1 completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("start");

      for (int v = 0; v < NV; v++)
         run_vector(V_FREQ[v], V_MODE[v], V_ACKD[v], V_POKE[v]);

      // R11: target never acknowledges
      begin
         int strobes;
         @(negedge clk);
         req_valid = 1'b1;
         req_freq  = 16'd454;
         @(negedge clk);
         req_valid = 1'b0;
         check("R11 first strobe", int'(cmd_valid), 1);
         strobes = 0;
         for (int k = 0; k < TMO + 10; k++) begin
            @(negedge clk);
            strobes += int'(cmd_valid);
         end
         check("R11 fault set", int'(fault), 1);
         check("R11 busy low", int'(busy), 0);
         check("R11 no further strobe", strobes, 0);
         req_valid = 1'b1;
         req_freq  = 16'd64;
         @(negedge clk);
         req_valid = 1'b0;
         for (int k = 0; k < 3; k++) begin
            check("R11 request ignored", int'(cmd_valid | busy | miss), 0);
            @(negedge clk);
         end
         check("R11 fault sticky", int'(fault), 1);
         check("R11 cur_freq", int'(cur_freq), model_cur);
      end

      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_cur = 24;
      @(negedge clk);
      check_reset_state("rerun");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule